// File: doc/BRIEF.md
# Command Packet Responder

This block sits behind the byte transport of a system controller and acts on complete packets from the host. The host side writes packet bytes into a small input store and then pulses `start` with the packet length. In the next cycle the responder has classified the packet, carried out the command, and placed a reply in an output store. A one-cycle `resp_valid` strobe announces the reply together with its length. The output store can be read at any time through a combinational address/data port.

The responder owns a 32-bit seconds count whose epoch is the first of January 1904. The count advances on a once-per-second tick input. It also owns the automatic device-polling settings: an enable, a period in milliseconds, and a 16-bit device mask. Power-down and system-reset requests leave the block as one-cycle pulses. Packets for the peripheral bus are not interpreted. The block announces them on a pass-through strobe, and their bytes stay readable through a second read port of the input store.

Top module: `cmd_responder`

## Requirements
- R1: After reset, polling is disabled, the poll period is 20 (0x14), the device mask is 0xFFFF, the seconds count is 0, and `resp_valid`, `bus_fwd`, `pwr_down` and `sys_reset` are all low.
- R2: A controller packet has type byte 1 in position 0 and the command byte in position 1. The argument count is the length minus 2. The reply is valid in the cycle after `start` is sampled. A success reply is the byte sequence 1, 0x00, command, then any result bytes, and `resp_len` is 3 plus the number of result bytes.
- R3: A command byte outside the supported set is answered with the 4-byte error reply 2, 0x02, 1, command, and changes no state.
- R4: A supported command with the wrong argument count is answered with the 4-byte error reply 2, 0x05, 1, command, and changes no state.
- R5: Command 0x01 takes one argument byte. A nonzero value enables polling and zero disables it.
- R6: Command 0x14 takes one argument byte, which sets the poll period in milliseconds. A value of 0 is answered with the 0x05 error reply, and the period is left unchanged.
- R7: Command 0x19 takes two argument bytes that form the device mask, most significant byte first.
- R8: The seconds count increments once per cycle in which `tick_1s` is high. Command 0x03 takes no arguments and returns the 4-byte count, most significant byte first, as held when `start` was sampled (reply length 7).
- R9: Command 0x09 takes four argument bytes and loads them into the seconds count, most significant first. A load takes priority over a tick in the same cycle.
- R10: Commands 0x0A (power down) and 0x11 (system reset) take no arguments. On success they raise `pwr_down` or `sys_reset` for exactly one cycle, aligned with `resp_valid`.
- R11: Commands 0x13 and 0x21 take one argument byte each. They are acknowledged with a success reply and change no state.
- R12: A packet of type 0 produces no reply. Instead, `bus_fwd` pulses for one cycle with `bus_fwd_len` equal to the packet length, and its bytes are readable at `fwd_addr`. Any other type, a zero length, or a controller packet shorter than 2 bytes produces no reply, no pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_we | input | 1 | Write one byte into the input store |
| in_addr | input | IDX_W (4) | Input store write address |
| in_data | input | 8 | Input store write byte |
| start | input | 1 | Process the stored packet |
| in_len | input | LEN_W (5) | Packet length in bytes, sampled with start |
| tick_1s | input | 1 | Once-per-second count enable |
| fwd_addr | input | IDX_W (4) | Read address into the input store for pass-through |
| fwd_data | output | 8 | Input store byte at fwd_addr |
| resp_valid | output | 1 | One-cycle reply-ready strobe |
| resp_len | output | LEN_W (5) | Reply length, valid with resp_valid |
| out_addr | input | OIDX_W (3) | Reply store read address |
| out_data | output | 8 | Reply byte at out_addr |
| bus_fwd | output | 1 | One-cycle strobe for a peripheral bus packet |
| bus_fwd_len | output | LEN_W (5) | Length of the forwarded packet |
| poll_en | output | 1 | Automatic polling enable |
| poll_rate | output | 8 | Poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| seconds | output | 32 | Seconds count since 1904 |
| pwr_down | output | 1 | Power-down request pulse |
| sys_reset | output | 1 | System reset request pulse |

## Verification
Every result of a packet is due one register stage after the clock edge that samples `start`. This applies to the reply strobe and its bytes, the pass-through strobe, the request pulses, and the updated poll and time registers. The bench raises `start` on a falling edge and lowers it on the next one. It then reads every strobe and register at that second falling edge, and it checks the request pulses a further cycle later to confirm they have dropped. The scoreboard monitor wakes on the falling edge where `resp_valid` is high. It walks the reply store while the stored reply is held stable, and it compares the result against the entry the driver queued before raising `start`. A tick lands in the seconds count one edge after it is sampled, so time checks are made only after the ticking cycles have ended.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEC_W    = 32;
    // bytes the decoder inspects: type, command, up to four arguments
    localparam int HEAD_N   = 6;
    // longest reply: type, status, command, four result bytes
    localparam int RESP_MAX = 7;

    localparam logic [7:0] PT_BUS  = 8'h00;
    localparam logic [7:0] PT_CTRL = 8'h01;
    localparam logic [7:0] PT_ERR  = 8'h02;

    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_BADARG  = 8'h05;

    localparam logic [7:0] OP_AUTOPOLL  = 8'h01;
    localparam logic [7:0] OP_GET_TIME  = 8'h03;
    localparam logic [7:0] OP_SET_TIME  = 8'h09;
    localparam logic [7:0] OP_POWER_OFF = 8'h0A;
    localparam logic [7:0] OP_SYS_RST   = 8'h11;
    localparam logic [7:0] OP_FS_FLAG   = 8'h13;
    localparam logic [7:0] OP_RATE      = 8'h14;
    localparam logic [7:0] OP_DEV_MASK  = 8'h19;
    localparam logic [7:0] OP_PWR_MSG   = 8'h21;

    typedef enum logic [1:0] {
        K_DROP  = 2'd0,
        K_FWD   = 2'd1,
        K_REPLY = 2'd2
    } kind_e;

    typedef struct packed {
        logic       known;
        logic [2:0] nargs;
    } cmd_info_t;

    typedef struct packed {
        logic              set_poll;
        logic              poll_val;
        logic              set_rate;
        logic [7:0]        rate;
        logic              set_mask;
        logic [15:0]       mask;
        logic              set_time;
        logic [SEC_W-1:0]  time_val;
        logic              pd;
        logic              sr;
    } action_t;

    function automatic cmd_info_t lookup(input logic [7:0] op);
        cmd_info_t r;
        r.known = 1'b1;
        case (op)
            OP_AUTOPOLL:  r.nargs = 3'd1;
            OP_GET_TIME:  r.nargs = 3'd0;
            OP_SET_TIME:  r.nargs = 3'd4;
            OP_POWER_OFF: r.nargs = 3'd0;
            OP_SYS_RST:   r.nargs = 3'd0;
            OP_FS_FLAG:   r.nargs = 3'd1;
            OP_RATE:      r.nargs = 3'd1;
            OP_DEV_MASK:  r.nargs = 3'd2;
            OP_PWR_MSG:   r.nargs = 3'd1;
            default: begin
                r.known = 1'b0;
                r.nargs = 3'd0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rsp_inbuf.sv
module rsp_inbuf
    import rsp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  waddr,
    input  logic [BYTE_W-1:0]                 wdata,
    input  logic [IDX_W-1:0]                  raddr,
    output logic [BYTE_W-1:0]                 rdata,
    output logic [HEAD_N-1:0][BYTE_W-1:0]     head
);

    logic [DEPTH-1:0][BYTE_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    for (genvar g = 0; g < HEAD_N; g++) begin : g_head
        assign head[g] = mem[g];
    end

endmodule

// File: rtl/rsp_decode.sv
module rsp_decode
    import rsp_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic [HEAD_N-1:0][BYTE_W-1:0]   head,
    input  logic [LEN_W-1:0]                len,
    input  logic [SEC_W-1:0]                secs,
    output kind_e                           kind,
    output logic [LEN_W-1:0]                rlen,
    output logic [RESP_MAX-1:0][BYTE_W-1:0] reply,
    output action_t                         act
);

    cmd_info_t        info;
    logic [LEN_W-1:0] nargs_in;
    logic             bad;
    logic [7:0]       op;

    always_comb begin
        op       = head[1];
        info     = lookup(op);
        nargs_in = len - LEN_W'(2);
        bad      = (nargs_in != LEN_W'(info.nargs)) ||
                   ((op == OP_RATE) && (head[2] == 8'h00));
        kind     = K_DROP;
        rlen     = '0;
        reply    = '0;
        act      = '0;
        if (len != '0) begin
            if (head[0] == PT_BUS) begin
                kind = K_FWD;
            end else if ((head[0] == PT_CTRL) && (len >= LEN_W'(2))) begin
                kind = K_REPLY;
                if (!info.known || bad) begin
                    reply[0] = PT_ERR;
                    reply[1] = info.known ? ERR_BADARG : ERR_UNKNOWN;
                    reply[2] = PT_CTRL;
                    reply[3] = op;
                    rlen     = LEN_W'(4);
                end else begin
                    reply[0] = PT_CTRL;
                    reply[1] = 8'h00;
                    reply[2] = op;
                    rlen     = LEN_W'(3);
                    case (op)
                        OP_AUTOPOLL: begin
                            act.set_poll = 1'b1;
                            act.poll_val = (head[2] != 8'h00);
                        end
                        OP_RATE: begin
                            act.set_rate = 1'b1;
                            act.rate     = head[2];
                        end
                        OP_DEV_MASK: begin
                            act.set_mask = 1'b1;
                            act.mask     = {head[2], head[3]};
                        end
                        OP_SET_TIME: begin
                            act.set_time = 1'b1;
                            act.time_val = {head[2], head[3], head[4], head[5]};
                        end
                        OP_GET_TIME: begin
                            reply[3] = secs[31:24];
                            reply[4] = secs[23:16];
                            reply[5] = secs[15:8];
                            reply[6] = secs[7:0];
                            rlen     = LEN_W'(7);
                        end
                        OP_POWER_OFF: act.pd = 1'b1;
                        OP_SYS_RST:   act.sr = 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/rsp_state.sv
module rsp_state
    import rsp_pkg::*;
#(
    parameter logic [7:0]  DEF_RATE = 8'd20,
    parameter logic [15:0] DEF_MASK = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply,
    input  logic             tick,
    input  action_t          act,
    output logic             poll_en,
    output logic [7:0]       poll_rate,
    output logic [15:0]      poll_mask,
    output logic [SEC_W-1:0] secs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_en   <= 1'b0;
            poll_rate <= DEF_RATE;
            poll_mask <= DEF_MASK;
            secs      <= '0;
        end else begin
            if (tick) begin
                secs <= secs + SEC_W'(1);
            end
            if (apply) begin
                if (act.set_time) secs      <= act.time_val;
                if (act.set_poll) poll_en   <= act.poll_val;
                if (act.set_rate) poll_rate <= act.rate;
                if (act.set_mask) poll_mask <= act.mask;
            end
        end
    end

endmodule

// File: rtl/rsp_outbuf.sv
module rsp_outbuf
    import rsp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int OIDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            load,
    input  logic [RESP_MAX-1:0][BYTE_W-1:0] data,
    input  logic [OIDX_W-1:0]               raddr,
    output logic [BYTE_W-1:0]               rdata
);

    logic [DEPTH-1:0][BYTE_W-1:0] mem;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g < RESP_MAX) begin : g_used
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[g] <= '0;
                end else if (load) begin
                    mem[g] <= data[g];
                end
            end
        end else begin : g_pad
            assign mem[g] = '0;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
    import rsp_pkg::*;
#(
    parameter int          IN_DEPTH  = 16,
    parameter int          OUT_DEPTH = 8,
    parameter logic [7:0]  DEF_RATE  = 8'd20,
    parameter logic [15:0] DEF_MASK  = 16'hFFFF,
    localparam int IDX_W  = $clog2(IN_DEPTH),
    localparam int LEN_W  = $clog2(IN_DEPTH + 1),
    localparam int OIDX_W = $clog2(OUT_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_we,
    input  logic [IDX_W-1:0]  in_addr,
    input  logic [7:0]        in_data,
    input  logic              start,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              tick_1s,
    input  logic [IDX_W-1:0]  fwd_addr,
    output logic [7:0]        fwd_data,
    output logic              resp_valid,
    output logic [LEN_W-1:0]  resp_len,
    input  logic [OIDX_W-1:0] out_addr,
    output logic [7:0]        out_data,
    output logic              bus_fwd,
    output logic [LEN_W-1:0]  bus_fwd_len,
    output logic              poll_en,
    output logic [7:0]        poll_rate,
    output logic [15:0]       poll_mask,
    output logic [31:0]       seconds,
    output logic              pwr_down,
    output logic              sys_reset
);

    logic [HEAD_N-1:0][BYTE_W-1:0]   head;
    kind_e                           kind;
    logic [LEN_W-1:0]                rlen;
    logic [RESP_MAX-1:0][BYTE_W-1:0] reply;
    action_t                         act;
    logic                            apply;

    assign apply = start && (kind == K_REPLY);

    rsp_inbuf #(.DEPTH(IN_DEPTH)) u_in (
        .clk   (clk),
        .rst   (rst),
        .we    (in_we),
        .waddr (in_addr),
        .wdata (in_data),
        .raddr (fwd_addr),
        .rdata (fwd_data),
        .head  (head)
    );

    rsp_decode #(.LEN_W(LEN_W)) u_dec (
        .head  (head),
        .len   (in_len),
        .secs  (seconds),
        .kind  (kind),
        .rlen  (rlen),
        .reply (reply),
        .act   (act)
    );

    rsp_state #(.DEF_RATE(DEF_RATE), .DEF_MASK(DEF_MASK)) u_st (
        .clk       (clk),
        .rst       (rst),
        .apply     (apply),
        .tick      (tick_1s),
        .act       (act),
        .poll_en   (poll_en),
        .poll_rate (poll_rate),
        .poll_mask (poll_mask),
        .secs      (seconds)
    );

    rsp_outbuf #(.DEPTH(OUT_DEPTH)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (apply),
        .data  (reply),
        .raddr (out_addr),
        .rdata (out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_len    <= '0;
            bus_fwd     <= 1'b0;
            bus_fwd_len <= '0;
            pwr_down    <= 1'b0;
            sys_reset   <= 1'b0;
        end else begin
            resp_valid <= apply;
            pwr_down   <= apply && act.pd;
            sys_reset  <= apply && act.sr;
            bus_fwd    <= start && (kind == K_FWD);
            if (apply) begin
                resp_len <= rlen;
            end
            if (start && (kind == K_FWD)) begin
                bus_fwd_len <= in_len;
            end
        end
    end

endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int IN_DEPTH = 16,
    localparam int LEN_W = $clog2(IN_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tick_1s,
    input logic             resp_valid,
    input logic [LEN_W-1:0] resp_len,
    input logic             bus_fwd,
    input logic             pwr_down,
    input logic             sys_reset,
    input logic             poll_en,
    input logic [7:0]       poll_rate,
    input logic [31:0]      seconds
);

    // R2
    reply_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(start));

    // R2
    reply_len_legal_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_len == 3 || resp_len == 4 || resp_len == 7));

    // R10
    pulse_with_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down || sys_reset) |-> resp_valid);

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        !(pwr_down && sys_reset));

    // R12
    fwd_no_reply_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_fwd && resp_valid));

    // R6
    rate_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        poll_rate != 8'h00);

    // R5
    poll_only_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> $stable(poll_en));

    // R8
    time_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(tick_1s)) |-> $stable(seconds));

    // R8
    time_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick_1s) && !$past(start)) |-> seconds == $past(seconds) + 32'd1);

endmodule

bind cmd_responder rsp_checker #(.IN_DEPTH(IN_DEPTH)) u_chk (.*);

// File: tb/sim_cmd_responder.sv
`timescale 1ns/1ps
module sim_cmd_responder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_we = 1'b0;
    logic [3:0]  in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        start = 1'b0;
    logic [4:0]  in_len = '0;
    logic        tick_1s = 1'b0;
    logic [3:0]  fwd_addr = '0;
    logic [7:0]  fwd_data;
    logic        resp_valid;
    logic [4:0]  resp_len;
    logic [2:0]  out_addr = '0;
    logic [7:0]  out_data;
    logic        bus_fwd;
    logic [4:0]  bus_fwd_len;
    logic        poll_en;
    logic [7:0]  poll_rate;
    logic [15:0] poll_mask;
    logic [31:0] seconds;
    logic        pwr_down;
    logic        sys_reset;

    always #5 clk = ~clk;

    cmd_responder u0 (.*);

    typedef struct {
        int          len;
        logic [63:0] bytes;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic obs_pd, obs_sr, obs_fwd, obs_pd2, obs_sr2, obs_rv;
    logic [4:0] obs_fwd_len;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            logic [63:0] got;
            int          glen;
            exp_t        e;
            glen = int'(resp_len);
            got  = '0;
            for (int i = 0; i < 8; i++) begin
                out_addr = 3'(i);
                #1;
                if (i < glen) got[63-8*i -: 8] = out_data;
            end
            if (q.size() == 0) begin
                check(0, "R2 unexpected reply", got, 64'h0);
            end else begin
                e = q.pop_front();
                check(glen == e.len, {e.tag, " length"}, 64'(glen), 64'(e.len));
                check(got == e.bytes, {e.tag, " bytes"}, got, e.bytes);
            end
        end
    end

    task automatic send(input logic [63:0] pk, input int n, input int elen,
                        input logic [63:0] ebytes, input string tag, input bit tick_now);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_we   = 1'b1;
            in_addr = 4'(i);
            in_data = pk[63-8*i -: 8];
        end
        @(negedge clk);
        in_we   = 1'b0;
        in_len  = 5'(n);
        start   = 1'b1;
        tick_1s = tick_now;
        if (elen > 0) begin
            e.len = elen; e.bytes = ebytes; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        start   = 1'b0;
        tick_1s = 1'b0;
        obs_rv      = resp_valid;
        obs_pd      = pwr_down;
        obs_sr      = sys_reset;
        obs_fwd     = bus_fwd;
        obs_fwd_len = bus_fwd_len;
        if (elen == 0) check(resp_valid == 1'b0, {tag, " no reply"}, 64'(resp_valid), 64'h0);
        @(negedge clk);
        obs_pd2 = pwr_down;
        obs_sr2 = sys_reset;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(poll_en == 1'b0, "R1 poll_en", 64'(poll_en), 64'h0);
        check(poll_rate == 8'd20, "R1 poll_rate", 64'(poll_rate), 64'd20);
        check(poll_mask == 16'hFFFF, "R1 poll_mask", 64'(poll_mask), 64'hFFFF);
        check(seconds == 32'd0, "R1 seconds", 64'(seconds), 64'h0);
        check({resp_valid, bus_fwd, pwr_down, sys_reset} == 4'b0, "R1 strobes",
              64'({resp_valid, bus_fwd, pwr_down, sys_reset}), 64'h0);

        // R5 autopoll
        send(64'h0101_0500_0000_0000, 3, 3, 64'h0100_0100_0000_0000, "R5 R2 autopoll on", 0);
        check(poll_en == 1'b1, "R5 enable", 64'(poll_en), 64'h1);
        send(64'h0101_0000_0000_0000, 3, 3, 64'h0100_0100_0000_0000, "R5 autopoll off", 0);
        check(poll_en == 1'b0, "R5 disable", 64'(poll_en), 64'h0);
        // R4 wrong count
        send(64'h0101_0000_0000_0000, 2, 4, 64'h0205_0101_0000_0000, "R4 autopoll no arg", 0);
        check(poll_en == 1'b0, "R4 state kept", 64'(poll_en), 64'h0);

        // R6 rate
        send(64'h0114_3200_0000_0000, 3, 3, 64'h0100_1400_0000_0000, "R6 rate set", 0);
        check(poll_rate == 8'h32, "R6 rate", 64'(poll_rate), 64'h32);
        send(64'h0114_0000_0000_0000, 3, 4, 64'h0205_0114_0000_0000, "R6 rate zero", 0);
        check(poll_rate == 8'h32, "R6 rate kept", 64'(poll_rate), 64'h32);

        // R7 mask
        send(64'h0119_A53C_0000_0000, 4, 3, 64'h0100_1900_0000_0000, "R7 mask set", 0);
        check(poll_mask == 16'hA53C, "R7 mask", 64'(poll_mask), 64'hA53C);
        send(64'h0119_7700_0000_0000, 3, 4, 64'h0205_0119_0000_0000, "R7 R4 mask short", 0);
        check(poll_mask == 16'hA53C, "R7 mask kept", 64'(poll_mask), 64'hA53C);

        // R9 set time
        send(64'h0109_1234_5678_0000, 6, 3, 64'h0100_0900_0000_0000, "R9 set time", 0);
        check(seconds == 32'h1234_5678, "R9 loaded", 64'(seconds), 64'h12345678);

        // R8 ticks then get time
        @(negedge clk);
        tick_1s = 1'b1;
        repeat (3) @(negedge clk);
        tick_1s = 1'b0;
        @(negedge clk);
        check(seconds == 32'h1234_567B, "R8 ticked", 64'(seconds), 64'h1234567B);
        send(64'h0103_0000_0000_0000, 2, 7, 64'h0100_0312_3456_7B00, "R8 get time", 0);
        send(64'h0103_0000_0000_0000, 3, 4, 64'h0205_0103_0000_0000, "R8 R4 get time arg", 0);

        // R9 load beats tick
        send(64'h0109_0000_0010_0000, 6, 3, 64'h0100_0900_0000_0000, "R9 set with tick", 1);
        check(seconds == 32'h10, "R9 priority", 64'(seconds), 64'h10);

        // R10 pulses
        send(64'h010A_0000_0000_0000, 2, 3, 64'h0100_0A00_0000_0000, "R10 power down", 0);
        check(obs_pd == 1'b1 && obs_sr == 1'b0, "R10 pd pulse", 64'({obs_pd, obs_sr}), 64'h2);
        check(obs_pd2 == 1'b0, "R10 pd one cycle", 64'(obs_pd2), 64'h0);
        send(64'h0111_0000_0000_0000, 2, 3, 64'h0100_1100_0000_0000, "R10 sys reset", 0);
        check(obs_sr == 1'b1 && obs_pd == 1'b0, "R10 sr pulse", 64'({obs_pd, obs_sr}), 64'h1);
        check(obs_sr2 == 1'b0, "R10 sr one cycle", 64'(obs_sr2), 64'h0);
        send(64'h010A_0000_0000_0000, 3, 4, 64'h0205_010A_0000_0000, "R10 R4 pd arg", 0);
        check(obs_pd == 1'b0, "R10 no pulse on error", 64'(obs_pd), 64'h0);

        // R11 acknowledged only
        send(64'h0113_0700_0000_0000, 3, 3, 64'h0100_1300_0000_0000, "R11 fs flag", 0);
        send(64'h0121_0100_0000_0000, 3, 3, 64'h0100_2100_0000_0000, "R11 pwr msg", 0);
        check({poll_en, poll_rate, poll_mask} == {1'b0, 8'h32, 16'hA53C}, "R11 state kept",
              64'({poll_en, poll_rate, poll_mask}), 64'({1'b0, 8'h32, 16'hA53C}));

        // R3 unknown
        send(64'h0155_0000_0000_0000, 2, 4, 64'h0202_0155_0000_0000, "R3 unknown", 0);
        send(64'h0102_0000_0000_0000, 2, 4, 64'h0202_0102_0000_0000, "R3 unknown 02", 0);

        // R12 pass-through and drops
        send(64'h0010_2000_0000_0000, 3, 0, 64'h0, "R12 bus packet", 0);
        check(obs_fwd == 1'b1 && obs_fwd_len == 5'd3, "R12 fwd strobe",
              64'({obs_fwd, obs_fwd_len}), 64'({1'b1, 5'd3}));
        fwd_addr = 4'd1;
        #1;
        check(fwd_data == 8'h10, "R12 fwd data", 64'(fwd_data), 64'h10);
        send(64'h0401_0000_0000_0000, 2, 0, 64'h0, "R12 other type", 0);
        check(obs_fwd == 1'b0, "R12 other no fwd", 64'(obs_fwd), 64'h0);
        send(64'h0100_0000_0000_0000, 1, 0, 64'h0, "R12 short ctrl", 0);
        check(seconds == 32'h10 && poll_rate == 8'h32, "R12 no state change",
              64'({seconds, poll_rate}), 64'({32'h10, 8'h32}));

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R2 all replies seen", 64'(q.size()), 64'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule